// File: doc/BRIEF.md
# Windowed Extended Register Bridge

This block answers two slots of a 32-entry management register space and uses them to reach a larger set of extended registers. The extended registers are grouped by device number, and each device has its own register addresses. One slot is a control register that holds a device number and a two-bit function code. The other slot is a window. Depending on the function code, the window either holds an extended register address or passes data to and from the extended register that the device number and the latched address select.

A management front end drives single-cycle read and write strobes with a 5-bit register number and 16-bit write data. Read data is combinational from the current address and state. Every state change takes effect at the clock edge on which the strobe is sampled. To write an extended register, software runs four steps: it writes the control register in address mode, writes the target address into the window, writes the control register in a data mode, then writes the value into the window. Two of the data modes advance the latched address by themselves, so a block of consecutive registers can be streamed through the window. The device count, registers per device and the two slot numbers are parameters; the defaults are 4 devices of 16 registers, with slots 13 and 14.

Top module: `ext_reg_window`

## Requirements
- R1: After reset, and after any later reset, the control slot reads 0x0000. The window reads 0x0000 because it is in address mode with a latched address of 0. Every extended register reads 0x0000.
- R2: A write to the control slot stores bits [15:14] as the function code and bits [4:0] as the device number. Reading it back returns those fields in the same positions, with bits [13:5] reading 0.
- R3: With function 00, a write to the window latches the 16-bit value as the extended register address. A read of the window returns the latched address.
- R4: With function 01, a window write stores the value into the selected extended register and a window read returns that register. The latched address does not change.
- R5: With function 10, every window read or write accesses the selected register, then advances the latched address by one. The address wraps from 0xFFFF to 0x0000.
- R6: With function 11, the latched address advances by one after each window write only. Window reads leave it unchanged.
- R7: When the device number is not below the device count, or the latched address is not below the per-device register count, window data reads return 0x0000 and window data writes change no register.
- R8: Each device keeps its own registers, so the same address under two device numbers selects two independent registers.
- R9: Reads of any slot other than the control and window slots return 0x0000. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed management slot |
| reg_rd | input | 1 | Read strobe for the addressed management slot (used for post-increment) |
| reg_addr | input | 5 | Management slot number |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |

## Verification
The main sequence runs the four-step write, then reads the same register back under a second device number. This shows that the device number takes part in selection. Block transfers in function 10 and function 11 are compared by where the address ends up after a mix of reads and writes, which separates increment-on-every-access from increment-on-write-only. Out-of-range device numbers and addresses are written with distinctive values, then a neighbouring register that a missing range check would alias onto is read back. Address wrap at 0xFFFF and a reset after activity are run as directed cases.

// File: rtl/ext_reg_window.sv
module ext_reg_window #(
  parameter int          NUM_DEV   = 4,
  parameter int          NUM_REG   = 16,
  parameter logic [4:0]  CTRL_SLOT = 5'd13,
  parameter logic [4:0]  DATA_SLOT = 5'd14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  localparam int DEPTH = NUM_DEV * NUM_REG;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [1:0] FN_ADDR  = 2'b00;
  localparam logic [1:0] FN_DATA  = 2'b01;
  localparam logic [1:0] FN_INC   = 2'b10;
  localparam logic [1:0] FN_INCWR = 2'b11;

  logic [1:0]  fn;
  logic [4:0]  dev;
  logic [15:0] ptr;
  logic [15:0] mem [DEPTH];

  wire ctrl_sel = reg_addr == CTRL_SLOT;
  wire win_sel  = reg_addr == DATA_SLOT;
  wire win_wr   = reg_wr && win_sel;
  wire win_acc  = (reg_wr || reg_rd) && win_sel;
  wire hit      = (int'(dev) < NUM_DEV) && (int'(ptr) < NUM_REG);

  logic [IDX_W-1:0] idx;
  always_comb idx = IDX_W'(int'(dev) * NUM_REG + int'(ptr));

  wire bump = (fn == FN_INC && win_acc) || (fn == FN_INCWR && win_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn  <= FN_ADDR;
      dev <= '0;
      ptr <= '0;
    end else if (reg_wr && ctrl_sel) begin
      fn  <= reg_wdata[15:14];
      dev <= reg_wdata[4:0];
    end else if (win_wr && fn == FN_ADDR) begin
      ptr <= reg_wdata;
    end else if (bump) begin
      ptr <= ptr + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (win_wr && fn != FN_ADDR && hit) begin
      mem[idx] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel)
      reg_rdata = {fn, 9'b0, dev};
    else if (win_sel)
      reg_rdata = (fn == FN_ADDR) ? ptr : (hit ? mem[idx] : 16'h0000);
  end

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ctrl_sel) |=> (reg_rdata == reg_rdata) && fn == $past(reg_wdata[15:14])
                             && dev == $past(reg_wdata[4:0]));

  assert_addr_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && fn == FN_ADDR) |=> ptr == $past(reg_wdata));

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && fn == FN_DATA) |=> $stable(ptr));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && fn == FN_INC) |=> ptr == $past(ptr) + 16'd1);

  assert_read_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && win_sel && fn == FN_INCWR) |=> $stable(ptr));

  assert_miss_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sel && fn != FN_ADDR && !hit) |-> reg_rdata == 16'h0000);

  assert_other_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_sel && !win_sel) |-> reg_rdata == 16'h0000);

  assert_other_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !ctrl_sel && !win_sel) |=> $stable(fn) && $stable(dev) && $stable(ptr));
endmodule

// File: tb/test_ext_reg_window.sv
`timescale 1ns/1ps
module test_ext_reg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ext_reg_window i_ext_reg_window (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // entry: {req[3:0], is_write, slot[4:0], write data or expected read data[15:0]}
  localparam int NV = 59;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 1'b1, 5'hD, 16'h0002}, {4'd2, 1'b0, 5'hD, 16'h0002},   // R2 control store
    {4'd3, 1'b1, 5'hE, 16'h0008}, {4'd3, 1'b0, 5'hE, 16'h0008},   // R3 address latch
    {4'd4, 1'b1, 5'hD, 16'h4002}, {4'd2, 1'b0, 5'hD, 16'h4002},
    {4'd4, 1'b1, 5'hE, 16'h03FF}, {4'd4, 1'b0, 5'hE, 16'h03FF},   // R4 data write/read
    {4'd4, 1'b1, 5'hD, 16'h0002}, {4'd4, 1'b0, 5'hE, 16'h0008},   // R4 address held
    {4'd8, 1'b1, 5'hD, 16'h4001}, {4'd8, 1'b0, 5'hE, 16'h0000},   // R8 other device
    {4'd8, 1'b1, 5'hE, 16'h1234}, {4'd8, 1'b0, 5'hE, 16'h1234},
    {4'd8, 1'b1, 5'hD, 16'h4002}, {4'd8, 1'b0, 5'hE, 16'h03FF},
    {4'd5, 1'b1, 5'hD, 16'h0002}, {4'd5, 1'b1, 5'hE, 16'h0003},   // R5 block write
    {4'd5, 1'b1, 5'hD, 16'h8002}, {4'd5, 1'b1, 5'hE, 16'hAAAA},
    {4'd5, 1'b1, 5'hE, 16'hBBBB}, {4'd5, 1'b1, 5'hD, 16'h0002},
    {4'd5, 1'b0, 5'hE, 16'h0005}, {4'd5, 1'b1, 5'hE, 16'h0003},
    {4'd5, 1'b1, 5'hD, 16'h8002}, {4'd5, 1'b0, 5'hE, 16'hAAAA},   // R5 block read
    {4'd5, 1'b0, 5'hE, 16'hBBBB}, {4'd5, 1'b1, 5'hD, 16'h0002},
    {4'd5, 1'b0, 5'hE, 16'h0005},
    {4'd6, 1'b1, 5'hE, 16'h000A}, {4'd6, 1'b1, 5'hD, 16'hC002},   // R6 write-only step
    {4'd6, 1'b1, 5'hE, 16'h1111}, {4'd6, 1'b0, 5'hE, 16'h0000},
    {4'd6, 1'b0, 5'hE, 16'h0000}, {4'd6, 1'b1, 5'hD, 16'h0002},
    {4'd6, 1'b0, 5'hE, 16'h000B}, {4'd6, 1'b1, 5'hE, 16'h000A},
    {4'd6, 1'b1, 5'hD, 16'h4002}, {4'd6, 1'b0, 5'hE, 16'h1111},
    {4'd7, 1'b1, 5'hD, 16'h0005}, {4'd7, 1'b1, 5'hE, 16'h0002},   // R7 device out of range
    {4'd7, 1'b1, 5'hD, 16'h4005}, {4'd7, 1'b1, 5'hE, 16'h5555},
    {4'd7, 1'b0, 5'hE, 16'h0000},
    {4'd7, 1'b1, 5'hD, 16'h0002}, {4'd7, 1'b1, 5'hE, 16'h0010},   // R7 address out of range
    {4'd7, 1'b1, 5'hD, 16'h4002}, {4'd7, 1'b1, 5'hE, 16'h7777},
    {4'd7, 1'b0, 5'hE, 16'h0000}, {4'd7, 1'b1, 5'hD, 16'h0003},
    {4'd7, 1'b1, 5'hE, 16'h0000}, {4'd7, 1'b1, 5'hD, 16'h4003},
    {4'd7, 1'b0, 5'hE, 16'h0000},                                 // R7 no alias onto dev 3 reg 0
    {4'd9, 1'b1, 5'h0, 16'hFFFF}, {4'd9, 1'b0, 5'h0, 16'h0000},   // R9 other slots
    {4'd9, 1'b0, 5'h1F, 16'h0000}, {4'd9, 1'b0, 5'hD, 16'h4003},
    {4'd2, 1'b1, 5'hD, 16'h3FE1}, {4'd2, 1'b0, 5'hD, 16'h0001}    // R2 middle bits dropped
  };

  task automatic op(input bit wr, input logic [4:0] a, input logic [15:0] d, input int req);
    @(negedge clk);
    reg_wr = wr; reg_rd = !wr; reg_addr = a; reg_wdata = wr ? d : 16'h0;
    #1;
    if (!wr) begin
      checks++;
      if (reg_rdata !== d) begin
        fails++;
        $display("FAIL R%0d slot %0h: actual %04h expected %04h", req, a, reg_rdata, d);
      end
    end
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    op(0, 5'hD, 16'h0000, 1);   // R1 reset state
    op(0, 5'hE, 16'h0000, 1);   // R1
    for (int i = 0; i < NV; i++)
      op(VEC[i][21], VEC[i][20:16], VEC[i][15:0], int'(VEC[i][25:22]));
    // R5 address wrap
    op(1, 5'hD, 16'h0000, 5);
    op(1, 5'hE, 16'hFFFF, 5);
    op(1, 5'hD, 16'h8000, 5);
    op(0, 5'hE, 16'h0000, 5);
    op(1, 5'hD, 16'h0000, 5);
    op(0, 5'hE, 16'h0000, 5);
    // R1 reset after activity clears window state and storage
    op(1, 5'hD, 16'h4002, 1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    op(0, 5'hD, 16'h0000, 1);
    op(0, 5'hE, 16'h0000, 1);
    op(1, 5'hE, 16'h0008, 1);
    op(1, 5'hD, 16'h4002, 1);
    op(0, 5'hE, 16'h0000, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule